// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a fully associative store of page translations. Each slot holds a validity flag, a virtual page number used as the tag, and a data word. The data word carries a physical page number, an 8-bit address-space number, a global flag, per-privilege-mode read and write enables, and fault-on-read and fault-on-write flags. A combinational lookup port takes a virtual page number and the current address-space number. It returns hit or miss, the slot index and the stored data word. Checking permissions and forming the physical address are left to the consumer.

New translations go into the slot chosen by a next-to-use pointer. That pointer also drives an index read-out port, which can step the pointer on its own. There are three single-cycle invalidation commands: clear everything, drop every entry of the current processes while keeping global ones, and drop the entries that match one page and address space.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits when it is valid, its tag equals `lk_vpn`, and either its global flag (data bit 10) is set or its stored address-space number (data bits 18:11) equals `lk_asn`. `lk_hit` reports this combinationally. On a miss, `lk_idx` and `lk_data` are zero.
- R2: When several slots hit, `lk_idx` and `lk_data` come from the lowest-numbered one.
- R3: An accepted insert writes `ins_vpn` as the tag and `ins_data` as the data into the slot at the pointer. It marks that slot valid and silently replaces whatever was there.
- R4: The pointer (`idx_slot`) advances by one per clock edge, wrapping from ENTRIES-1 to 0, when an insert is accepted or `idx_adv` is high. Both together advance it once.
- R5: `idx_valid`, `idx_vpn` and `idx_data` always show the slot the pointer selects.
- R6: `fl_all` clears the valid flag, tag and data of every slot and sets the pointer to 0. In that cycle every other command and `idx_adv` are ignored.
- R7: `fl_proc` invalidates every slot whose global flag is clear and leaves global slots valid.
- R8: `fl_addr` invalidates every slot that would hit under the R1 rule for `fl_vpn` and `fl_asn`.
- R9: Only one command is applied per cycle, in the priority `fl_all`, then `fl_proc`, then `fl_addr`, then insert. An insert dropped for this reason does not advance the pointer.
- R10: After reset every slot is invalid with zero tag and data, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Matching slot index |
| lk_data | output | DATA_W | Matching slot data word |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag for insert |
| ins_data | input | DATA_W | Data word for insert |
| idx_adv | input | 1 | Step pointer after read-out |
| idx_valid | output | 1 | Valid flag of pointed slot |
| idx_vpn | output | VPN_W | Tag of pointed slot |
| idx_data | output | DATA_W | Data of pointed slot |
| idx_slot | output | IDX_W | Current pointer value |
| fl_all | input | 1 | Invalidate everything |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_addr | input | 1 | Invalidate slots matching one page |
| fl_vpn | input | VPN_W | Page number for flush-by-address |
| fl_asn | input | ASN_W | Address-space number for flush-by-address |

## Verification
The hardest state to reach is a buffer holding several valid slots with the same tag under different address spaces, mixed with global slots, at the moment two commands collide. The stimulus draws tags and address-space numbers from very small pools and sets the global flag often, so duplicate matches and global overrides are common. It issues flushes together with inserts and pointer steps, and inserts more entries than there are slots so that the pointer wraps and valid slots are overwritten. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 20;
  localparam int ASN_W   = 8;
  localparam int MODES   = 4;
  localparam int GLB_POS = 2 + 2 * MODES;
  localparam int ASN_POS = GLB_POS + 1;
  localparam int DATA_W  = ASN_POS + ASN_W + PPN_W;

  function automatic logic data_global(input logic [DATA_W-1:0] d);
    return d[GLB_POS];
  endfunction

  function automatic logic [ASN_W-1:0] data_asn(input logic [DATA_W-1:0] d);
    return d[ASN_POS +: ASN_W];
  endfunction

  // hit rule: valid, tag equal, and global or same address space
  function automatic logic slot_match(input logic v, input logic [VPN_W-1:0] tag,
                                      input logic [DATA_W-1:0] d,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASN_W-1:0] asn);
    return v && (tag == vpn) && (data_global(d) || (data_asn(d) == asn));
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  valid,
  input  logic [VPN_W-1:0]    tags  [ENTRIES],
  input  logic [DATA_W-1:0]   datas [ENTRIES],
  input  logic [VPN_W-1:0]    vpn,
  input  logic [ASN_W-1:0]    asn,
  output logic [ENTRIES-1:0]  hits,
  output logic                any,
  output logic [IDX_W-1:0]    first
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hits[i] = slot_match(valid[i], tags[i], datas[i], vpn, asn);
  end

  assign any = |hits;

  always_comb begin
    first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hits[i]) first = IDX_W'(i);
  end

  // R2
  lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (hits[first] && ((hits & ((ENTRIES'(1) << first) - ENTRIES'(1))) == '0)));
endmodule

// File: rtl/tlb_nlu_ptr.sv
module tlb_nlu_ptr #(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clear)  ptr <= '0;
    else if (step)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr <= LAST);
  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clear |=> ptr == '0);
endmodule

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic [ENTRIES-1:0] inv_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [ENTRIES-1:0] valid,
  output logic [VPN_W-1:0]   tags  [ENTRIES],
  output logic [DATA_W-1:0]  datas [ENTRIES]
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_here;
    assign wr_here = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[i] <= 1'b0;
        tags[i]  <= '0;
        datas[i] <= '0;
      end else if (clr_all) begin
        valid[i] <= 1'b0;
        tags[i]  <= '0;
        datas[i] <= '0;
      end else if (wr_here) begin
        valid[i] <= 1'b1;
        tags[i]  <= wr_vpn;
        datas[i] <= wr_data;
      end else if (inv_vec[i]) begin
        valid[i] <= 1'b0;
      end
    end
  end

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_all |=> valid == '0);
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb import tlb_pkg::*; #(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  input  logic              ins_en,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              idx_adv,
  output logic              idx_valid,
  output logic [VPN_W-1:0]  idx_vpn,
  output logic [DATA_W-1:0] idx_data,
  output logic [IDX_W-1:0]  idx_slot,
  input  logic              fl_all,
  input  logic              fl_proc,
  input  logic              fl_addr,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn
);
  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   tags  [ENTRIES];
  logic [DATA_W-1:0]  datas [ENTRIES];
  logic [ENTRIES-1:0] lk_hits, fl_hits, local_vec, inv_vec;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_first, fl_first, ptr;

  // command arbitration (named events for the assertions)
  logic all_go, proc_go, addr_go, ins_go, step_go, any_local_valid;
  assign all_go  = fl_all;
  assign proc_go = fl_proc && !fl_all;
  assign addr_go = fl_addr && !fl_all && !fl_proc;
  assign ins_go  = ins_en && !(fl_all || fl_proc || fl_addr);
  assign step_go = !fl_all && (ins_go || idx_adv);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_local
    assign local_vec[i] = valid[i] && !data_global(datas[i]);
  end
  assign any_local_valid = |local_vec;

  assign inv_vec = proc_go ? local_vec : (addr_go ? fl_hits : '0);

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(all_go), .inv_vec(inv_vec),
    .wr_en(ins_go), .wr_idx(ptr), .wr_vpn(ins_vpn), .wr_data(ins_data),
    .valid(valid), .tags(tags), .datas(datas));

  tlb_nlu_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(all_go), .step(step_go), .ptr(ptr));

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .valid(valid), .tags(tags), .datas(datas),
    .vpn(lk_vpn), .asn(lk_asn), .hits(lk_hits), .any(lk_any), .first(lk_first));

  tlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
    .clk(clk), .rst_n(rst_n), .valid(valid), .tags(tags), .datas(datas),
    .vpn(fl_vpn), .asn(fl_asn), .hits(fl_hits), .any(fl_any), .first(fl_first));

  assign lk_hit    = lk_any;
  assign lk_idx    = lk_any ? lk_first : '0;
  assign lk_data   = lk_any ? datas[lk_first] : '0;
  assign idx_valid = valid[ptr];
  assign idx_vpn   = tags[ptr];
  assign idx_data  = datas[ptr];
  assign idx_slot  = ptr;

  // R1
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid[lk_idx] && tags[lk_idx] == lk_vpn));
  // R3
  ins_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> (valid[$past(ptr)] && tags[$past(ptr)] == $past(ins_vpn)));
  // R7
  proc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proc_go |=> !any_local_valid);
  // R8
  addr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_go && fl_any) |=> !valid[$past(fl_first)]);
  // R9
  ins_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && fl_proc && !idx_adv) |=> $stable(ptr));
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int PERIOD = 10;
  localparam int E = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [19:0] lk_vpn = 0, ins_vpn = 0, fl_vpn = 0, idx_vpn;
  logic [7:0]  lk_asn = 0, fl_asn = 0;
  logic        lk_hit, ins_en = 0, idx_adv = 0, idx_valid, fl_all = 0, fl_proc = 0, fl_addr = 0;
  logic [IW-1:0] lk_idx, idx_slot;
  logic [38:0] lk_data, ins_data = 0, idx_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  asn_tlb #(.ENTRIES(E)) u_dut (.*);

  // behavioural reference
  bit          m_v[E];
  logic [19:0] m_t[E];
  logic [38:0] m_d[E];
  int          m_p;

  function automatic bit m_hit(int i, logic [19:0] vpn, logic [7:0] asn);
    return m_v[i] && m_t[i] == vpn && (m_d[i][10] == 1'b1 || m_d[i][18:11] == asn);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_t[i] = 0; m_d[i] = 0; end
      m_p = 0;
    end else if (fl_all) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_t[i] = 0; m_d[i] = 0; end
      m_p = 0;
    end else begin
      bit took;
      took = 0;
      if (fl_proc) begin
        foreach (m_v[i]) if (m_d[i][10] == 1'b0) m_v[i] = 0;
      end else if (fl_addr) begin
        bit kill[E];
        foreach (m_v[i]) kill[i] = m_hit(i, fl_vpn, fl_asn);
        foreach (m_v[i]) if (kill[i]) m_v[i] = 0;
      end else if (ins_en) begin
        m_v[m_p] = 1; m_t[m_p] = ins_vpn; m_d[m_p] = ins_data; took = 1;
      end
      if (took || idx_adv) m_p = (m_p + 1) % E;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int h;
    h = -1;
    for (int i = E - 1; i >= 0; i--) if (m_hit(i, lk_vpn, lk_asn)) h = i;
    chk("R1 lk_hit", 64'(lk_hit), 64'(h >= 0));
    chk("R2 lk_idx", 64'(lk_idx), (h >= 0) ? 64'(h) : 64'd0);
    chk("R2 lk_data", 64'(lk_data), (h >= 0) ? 64'(m_d[h]) : 64'd0);
    chk("R4 idx_slot", 64'(idx_slot), 64'(m_p));
    chk("R5 idx_valid", 64'(idx_valid), 64'(m_v[m_p]));
    chk("R5 idx_vpn", 64'(idx_vpn), 64'(m_t[m_p]));
    chk("R5 idx_data", 64'(idx_data), 64'(m_d[m_p]));
  endtask

  function automatic logic [38:0] mk(int ppn, int asn, bit g);
    return {20'(ppn), 8'(asn), g, 4'hF, 4'h3, 1'b0, 1'b1};
  endfunction

  task automatic idle();
    ins_en = 0; idx_adv = 0; fl_all = 0; fl_proc = 0; fl_addr = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic ins(int vpn, logic [38:0] d);
    ins_en = 1; ins_vpn = 20'(vpn); ins_data = d; tick();
  endtask

  task automatic look(int vpn, int asn, bit eh, int ei, string tag);
    lk_vpn = 20'(vpn); lk_asn = 8'(asn); #1;
    chk(tag, 64'(lk_hit), 64'(eh));
    if (eh) chk(tag, 64'(lk_idx), 64'(ei));
    compare_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 idx_valid", 64'(idx_valid), 0);
    chk("R10 idx_slot", 64'(idx_slot), 0);
    rst_n = 1;
    @(negedge clk); #1;

    ins(5, mk(100, 1, 0));
    look(5, 1, 1, 0, "R3 insert hit");
    look(5, 2, 0, 0, "R1 asn mismatch miss");
    ins(7, mk(200, 3, 1));
    look(7, 9, 1, 1, "R1 global override");
    ins(5, mk(300, 1, 0));
    look(5, 1, 1, 0, "R2 lowest index");
    // R9: insert alongside process flush is dropped
    fl_proc = 1; ins_en = 1; ins_vpn = 20'd9; ins_data = mk(1, 1, 0); tick();
    chk("R9 ptr held", 64'(idx_slot), 3);
    look(9, 1, 0, 0, "R9 insert dropped");
    look(5, 1, 0, 0, "R7 local flushed");
    look(7, 4, 1, 1, "R7 global kept");
    fl_addr = 1; fl_vpn = 20'd7; fl_asn = 8'd0; tick();
    look(7, 4, 0, 0, "R8 addr flush");
    for (int k = 0; k < 6; k++) ins(20 + k, mk(k, 2, 0));
    chk("R4 wrap", 64'(idx_slot), 1);
    look(25, 2, 1, 0, "R3 overwrite slot0");
    idx_adv = 1; tick();
    chk("R5 advance", 64'(idx_slot), 2);
    chk("R5 data", 64'(idx_data), 64'(mk(300, 1, 0)));
    fl_all = 1; ins_en = 1; idx_adv = 1; tick();
    chk("R6 ptr zero", 64'(idx_slot), 0);
    look(25, 2, 0, 0, "R6 all invalid");

    // random mixed traffic with dense collisions
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 100;
      ins_en  = r < 55;
      idx_adv = ($urandom % 6) == 0;
      fl_proc = (r >= 55 && r < 62) || ($urandom % 40 == 0);
      fl_addr = (r >= 62 && r < 75);
      fl_all  = (r == 99);
      ins_vpn = 20'($urandom % 6);
      ins_data = mk($urandom % 1000, $urandom % 3, ($urandom % 4) == 0);
      fl_vpn = 20'($urandom % 6); fl_asn = 8'($urandom % 3);
      lk_vpn = 20'($urandom % 6); lk_asn = 8'($urandom % 3);
      #1; compare_all();
      @(posedge clk); @(negedge clk);
      #1; compare_all();
    end
    idle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule